// File: doc/BRIEF.md
# Selective-Insertion Reuse Cache Controller

This block controls a small last-level cache whose tag store and data store are decoupled. The tag store is set-associative and tracks far more lines than the data store can hold. Each tag entry records whether the line's data is resident and, if so, which data slot holds it. A line gets a tag on its first reference. It is given data storage only when a tracked tag is referenced again, so lines that are touched once never consume data capacity.

Requests arrive one at a time over a valid/busy handshake. The block serves a request from its own data store when both tag and data are present. Otherwise it fetches the line over a single request/response memory port and forwards the fetched word straight to the requester. Tag replacement uses a one-bit not-recently-reused mark per entry with a pseudo-random choice among marked ways. When the data store is full, slots are reclaimed by a rotating hand, and the owning tag is left tracked but marked as having no data.

Top module: `reuse_cache`

## Requirements
- R1: After reset the block is idle: `busy`, `rspValid` and `memReqValid` are all 0.
- R2: A request whose tag is not tracked fetches the line from memory exactly once and responds with the fetched word and `rspHit`=0. The word is not kept, so the next request to the same line fetches from memory again.
- R3: A request whose tag is tracked but has no data fetches from memory once and responds with `rspHit`=0. The fetched word is placed in a data slot, so the following request to that line is served without memory.
- R4: A request whose tag and data are both present responds with `rspHit`=1 and the stored word, and issues no memory request.
- R5: A newly inserted tag has its reuse mark set to 1, and any later request to it clears the mark. When a set has no free way, the replaced way is one whose mark is 1. Ways with a cleared mark survive.
- R6: If every way of a full set has a cleared mark, all marks of the set are set to 1 and a victim is still chosen, so the new tag is inserted and becomes tracked.
- R7: Replacing a tag whose data is resident releases that data slot. A later data allocation takes a released slot before displacing any resident line.
- R8: When no data slot is free, allocation takes the slot under a rotating hand starting at slot 0. The line that owned it keeps its tag but loses its data: its next request fetches from memory with `rspHit`=0, and the request after that is served from the data store again.
- R9: Free data slots are handed out lowest index first.
- R10: `busy` is 1 from the cycle after a request is accepted until the response cycle ends. `rspValid` is a one-cycle pulse. Requests presented while `busy` is 1 are ignored and produce neither a response nor a memory fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; accepted when `busy` is 0 |
| reqAddr | input | 12 | Line address: bits 3:0 set index, bits 11:4 tag |
| busy | output | 1 | A request is in progress |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 32 | Line word for the response |
| rspHit | output | 1 | 1 when served from the data store, 0 when fetched |
| memReqValid | output | 1 | Memory fetch request, held until `memRspValid` |
| memReqAddr | output | 12 | Line address of the fetch |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 32 | Word returned by memory |

## Verification
The bench separates the three request kinds by counting memory fetches and checking the hit flag. A design that kept data on the first miss would turn the second request into a hit, and one that never allocated data would keep fetching on the third. It fills one set with four reused lines and adds a fifth. A design that ignored the reuse mark, or stalled when every mark was clear, would lose a reused line or fail to track the newcomer. It fills the entire data store before replacing a tag that owns data. A design that did not release the slot would displace the line in slot 0, which the bench then finds missing. A design whose hand did not mark the displaced owner would return stale data instead of fetching.

// File: rtl/reuse_cache_pkg.sv
package reuse_cache_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch the incoming request address
    logic touch;     // full hit: clear reuse mark, load response from data store
    logic fillTag;   // untracked miss: insert tag only
    logic fillData;  // tracked miss: allocate a data slot for the hit way
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FETCH = 2'd2,
    ST_RESP  = 2'd3
  } ctlState_t;

endpackage

// File: rtl/reuse_cache_dp.sv
module reuse_cache_dp
  import reuse_cache_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int SLOTS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memRspData,
  output logic              tagHit,
  output logic              dataHit,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] rspData
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SET_W  = $clog2(SETS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int RND_W  = 16;

  // tag store
  logic [WAYS-1:0]   tValid   [SETS];
  logic [WAYS-1:0]   tNrr     [SETS];
  logic [WAYS-1:0]   tHasData [SETS];
  logic [TAG_W-1:0]  tTag     [SETS][WAYS];
  logic [SLOT_W-1:0] tPtr     [SETS][WAYS];

  // data store with back pointers
  logic [SLOTS-1:0]  sValid;
  logic [DATA_W-1:0] sData [SLOTS];
  logic [SET_W-1:0]  sSet  [SLOTS];
  logic [WAY_W-1:0]  sWay  [SLOTS];

  logic [SLOT_W-1:0] hand;
  logic [RND_W-1:0]  lfsr;

  logic [SET_W-1:0]  curSet;
  logic [TAG_W-1:0]  curTag;
  logic [WAYS-1:0]   hitVec;
  logic [WAY_W-1:0]  hitWay;
  logic [WAYS-1:0]   eligVec;
  logic              anyFree, anyMarked, needRefill;
  logic [WAY_W-1:0]  victimWay, startIdx, probe;
  logic [SLOT_W-1:0] victimPtr;
  logic              freeFound;
  logic [SLOT_W-1:0] freeSlot, allocSlot;

  assign curSet = curAddr[SET_W-1:0];
  assign curTag = curAddr[ADDR_W-1:SET_W];

  // lookup
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = tValid[curSet][w] && (tTag[curSet][w] == curTag);
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
    tagHit  = |hitVec;
    dataHit = tagHit && tHasData[curSet][hitWay];
  end

  // tag victim: first eligible way at or after a pseudo-random start
  assign anyFree    = ~&tValid[curSet];
  assign anyMarked  = |tNrr[curSet];
  assign needRefill = !anyFree && !anyMarked;
  assign startIdx   = lfsr[WAY_W-1:0];

  always_comb begin
    if (anyFree)        eligVec = ~tValid[curSet];
    else if (anyMarked) eligVec = tNrr[curSet];
    else                eligVec = '1;
    victimWay = startIdx;
    for (int k = WAYS - 1; k >= 0; k--) begin
      probe = startIdx + WAY_W'(k);
      if (eligVec[probe]) victimWay = probe;
    end
  end

  assign victimPtr = tPtr[curSet][victimWay];

  // data slot: lowest free slot, otherwise the hand position
  always_comb begin
    freeFound = 1'b0;
    freeSlot  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!sValid[s]) begin
        freeFound = 1'b1;
        freeSlot  = SLOT_W'(s);
      end
    end
    allocSlot = freeFound ? freeSlot : hand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      rspData <= '0;
      hand    <= '0;
      lfsr    <= 16'hACE1;
      sValid  <= '0;
      for (int i = 0; i < SETS; i++) begin
        tValid[i]   <= '0;
        tNrr[i]     <= '0;
        tHasData[i] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tTag[i][w] <= '0;
          tPtr[i][w] <= '0;
        end
      end
      for (int s = 0; s < SLOTS; s++) begin
        sData[s] <= '0;
        sSet[s]  <= '0;
        sWay[s]  <= '0;
      end
    end else begin
      lfsr <= {lfsr[RND_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

      if (ctl.capture) curAddr <= reqAddr;

      if (ctl.touch) begin
        tNrr[curSet][hitWay] <= 1'b0;
        rspData <= sData[tPtr[curSet][hitWay]];
      end

      if (ctl.fillTag) begin
        rspData <= memRspData;
        if (needRefill) tNrr[curSet] <= '1;
        if (tValid[curSet][victimWay] && tHasData[curSet][victimWay])
          sValid[victimPtr] <= 1'b0;
        tValid[curSet][victimWay]   <= 1'b1;
        tTag[curSet][victimWay]     <= curTag;
        tNrr[curSet][victimWay]     <= 1'b1;
        tHasData[curSet][victimWay] <= 1'b0;
      end

      if (ctl.fillData) begin
        rspData <= memRspData;
        if (!freeFound) begin
          tHasData[sSet[allocSlot]][sWay[allocSlot]] <= 1'b0;
          hand <= hand + 1'b1;
        end
        sValid[allocSlot] <= 1'b1;
        sData[allocSlot]  <= memRspData;
        sSet[allocSlot]   <= curSet;
        sWay[allocSlot]   <= hitWay;
        tHasData[curSet][hitWay] <= 1'b1;
        tPtr[curSet][hitWay]     <= allocSlot;
        tNrr[curSet][hitWay]     <= 1'b0;
      end
    end
  end

  // R5: an occupied way is replaced only if marked (or after a refill)
  p_victim_marked_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillTag |-> (!tValid[curSet][victimWay] || tNrr[curSet][victimWay] || needRefill));

  // R6: an all-clear full set has every mark set after the insertion
  p_refill_marks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillTag && needRefill) |=> (&tNrr[$past(curSet)]));

  // R7: replacing a tag that owns data frees its slot
  p_slot_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillTag && tValid[curSet][victimWay] && tHasData[curSet][victimWay])
      |=> !sValid[$past(victimPtr)]);

  // R3: a data fill leaves the tag marked as data-present
  p_fill_sets_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillData |=> dataHit);

endmodule

// File: rtl/reuse_cache_ctl.sv
module reuse_cache_ctl
  import reuse_cache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    tagHit,
  input  logic    dataHit,
  input  logic    memRspValid,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    rspValid,
  output logic    rspHit,
  output logic    memReqValid
);
  ctlState_t state, stateNext;
  logic      hitReg;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        stateNext   = ST_LOOK;
      end
      ST_LOOK: begin
        if (dataHit) begin
          ctl.touch = 1'b1;
          stateNext = ST_RESP;
        end else begin
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: if (memRspValid) begin
        ctl.fillData = tagHit;
        ctl.fillTag  = !tagHit;
        stateNext    = ST_RESP;
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hitReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.touch) hitReg <= 1'b1;
      else if (ctl.fillTag || ctl.fillData) hitReg <= 1'b0;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign rspValid    = (state == ST_RESP);
  assign rspHit      = hitReg;
  assign memReqValid = (state == ST_FETCH);

  // R10: single-cycle response, then idle
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && !busy));

  // R2: a fetch request stays up until memory answers
  p_memreq_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid);

  // R4: a full hit answers next cycle with the hit flag and no fetch
  p_hit_no_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOK && dataHit) |=> (rspValid && rspHit && !memReqValid));

endmodule

// File: rtl/reuse_cache.sv
module reuse_cache
  import reuse_cache_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int SLOTS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspHit,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);
  dpCtrl_t ctl;
  logic    tagHit, dataHit;

  reuse_cache_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .tagHit      (tagHit),
    .dataHit     (dataHit),
    .memRspValid (memRspValid),
    .ctl         (ctl),
    .busy        (busy),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .memReqValid (memReqValid)
  );

  reuse_cache_dp #(
    .WAYS   (WAYS),
    .SETS   (SETS),
    .SLOTS  (SLOTS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .memRspData (memRspData),
    .tagHit     (tagHit),
    .dataHit    (dataHit),
    .curAddr    (memReqAddr),
    .rspData    (rspData)
  );

endmodule

// File: tb/reuse_cache_tb.sv
module reuse_cache_tb;
  localparam int MEM_LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] reqAddr = '0;
  logic        busy, rspValid, rspHit, memReqValid;
  logic [31:0] rspData;
  logic [11:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  int checks = 0;
  int fails  = 0;
  int fetchCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reuse_cache u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .rspValid(rspValid), .rspData(rspData), .rspHit(rspHit),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [31:0] memWord(input logic [11:0] a);
    return {a, 8'hC3, ~a} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [11:0] mkAddr(input int tagV, input int setV);
    return {8'(tagV), 4'(setV)};
  endfunction

  // memory model
  initial begin
    logic [11:0] a;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memReqValid && !memRspValid) begin
        fetchCount++;
        a = memReqAddr;
        repeat (MEM_LAT - 1) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = memWord(a);
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doAccess(input logic [11:0] a, output logic hitO,
                          output logic [31:0] dataO, output int fetchesO);
    int f0;
    int guard;
    f0 = fetchCount;
    while (busy) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!rspValid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (!rspValid) chk(1'b0, "R10", "response timeout", 0, 1);
    hitO     = rspHit;
    dataO    = rspData;
    fetchesO = fetchCount - f0;
    @(negedge clk);
  endtask

  task automatic accessChk(input logic [11:0] a, input logic expHit,
                           input int expFetch, input string req);
    logic h;
    logic [31:0] d;
    int f;
    doAccess(a, h, d, f);
    chk(h == expHit, req, $sformatf("hit flag @%0h", a), 32'(h), 32'(expHit));
    chk(d == memWord(a), req, $sformatf("data @%0h", a), d, memWord(a));
    chk(f == expFetch, req, $sformatf("fetches @%0h", a), 32'(f), 32'(expFetch));
  endtask

  task automatic quiet(input logic [11:0] a);
    logic h;
    logic [31:0] d;
    int f;
    doAccess(a, h, d, f);
  endtask

  // R1
  task automatic testReset();
    doReset();
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(rspValid == 1'b0, "R1", "rspValid after reset", 32'(rspValid), 0);
    chk(memReqValid == 1'b0, "R1", "memReqValid after reset", 32'(memReqValid), 0);
  endtask

  // R2, R3, R4: three-step life of one line, two different lines
  task automatic testLifecycle();
    doReset();
    accessChk(mkAddr(7, 3), 1'b0, 1, "R2");
    accessChk(mkAddr(7, 3), 1'b0, 1, "R3");
    accessChk(mkAddr(7, 3), 1'b1, 0, "R4");
    accessChk(mkAddr(200, 12), 1'b0, 1, "R2");
    accessChk(mkAddr(7, 3), 1'b1, 0, "R4");
    accessChk(mkAddr(200, 12), 1'b0, 1, "R3");
    accessChk(mkAddr(200, 12), 1'b1, 0, "R4");
  endtask

  // R5: only the unmarked... the marked way goes; reused ways survive
  task automatic testMarkVictim();
    doReset();
    for (int t = 1; t <= 4; t++) quiet(mkAddr(t, 15));
    for (int t = 1; t <= 3; t++) quiet(mkAddr(t, 15));
    accessChk(mkAddr(5, 15), 1'b0, 1, "R5");
    for (int t = 1; t <= 3; t++) accessChk(mkAddr(t, 15), 1'b1, 0, "R5");
  endtask

  // R6, R7, R8, R9: fill the whole data store, then replace tags and slots
  task automatic testCapacity();
    doReset();
    for (int i = 0; i < 28; i++) begin
      quiet(mkAddr(1 + i % 4, 1 + i / 4));
      quiet(mkAddr(1 + i % 4, 1 + i / 4));
    end
    for (int t = 1; t <= 4; t++) begin
      quiet(mkAddr(t, 0));
      quiet(mkAddr(t, 0));
    end
    // R9: slots went out lowest first, so all 32 lines are resident
    accessChk(mkAddr(4, 7), 1'b1, 0, "R9");
    accessChk(mkAddr(1, 1), 1'b1, 0, "R9");
    // R6: all marks clear in set 0, new tag still goes in and is tracked
    accessChk(mkAddr(9, 0), 1'b0, 1, "R6");
    accessChk(mkAddr(9, 0), 1'b0, 1, "R6");
    accessChk(mkAddr(9, 0), 1'b1, 0, "R6");
    // R7: the released slot was reused, so the line in slot 0 is intact
    accessChk(mkAddr(1, 1), 1'b1, 0, "R7");
    accessChk(mkAddr(2, 1), 1'b1, 0, "R7");
    // R8: store full, next allocation displaces slot 0 (set 1 tag 1)
    quiet(mkAddr(1, 8));
    accessChk(mkAddr(1, 8), 1'b0, 1, "R8");
    accessChk(mkAddr(1, 8), 1'b1, 0, "R8");
    accessChk(mkAddr(1, 1), 1'b0, 1, "R8");
    accessChk(mkAddr(1, 1), 1'b1, 0, "R8");
    // hand moved on to slot 1 (set 1 tag 2)
    accessChk(mkAddr(2, 1), 1'b0, 1, "R8");
  endtask

  // R10: requests during busy are dropped
  task automatic testBusy();
    int f0;
    int rspCount;
    logic [31:0] got;
    doReset();
    f0 = fetchCount;
    rspCount = 0;
    got = '0;
    reqValid = 1'b1;
    reqAddr  = mkAddr(33, 5);
    @(negedge clk);
    reqAddr = mkAddr(44, 6);
    chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (rspValid) begin
        rspCount++;
        got = rspData;
      end
      @(negedge clk);
    end
    chk(rspCount == 1, "R10", "responses", 32'(rspCount), 1);
    chk(got == memWord(mkAddr(33, 5)), "R10", "response data", got, memWord(mkAddr(33, 5)));
    chk(fetchCount - f0 == 1, "R10", "fetches", 32'(fetchCount - f0), 1);
    chk(busy == 1'b0, "R10", "idle afterwards", 32'(busy), 0);
    // the dropped line was never tracked: its first request is a plain miss
    accessChk(mkAddr(44, 6), 1'b0, 1, "R10");
    accessChk(mkAddr(33, 5), 1'b0, 1, "R10");
    accessChk(mkAddr(33, 5), 1'b1, 0, "R10");
  endtask

  initial begin
    testReset();
    testLifecycle();
    testMarkVictim();
    testCapacity();
    testBusy();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule